// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a byte-wide record of which reset events have fired since software last cleared it. Five sources feed it: power-on, the external reset pin, brown-out detection, the watchdog and a debug-port reset request. Each source may be a short pulse or a held level, and none needs to be related to the register clock. Every input first passes through its own synchroniser chain. When a synchronised input is high, the matching flag is set. Flags are sticky: once set, a flag stays set until software clears it or, for every flag except the power-on flag, until a power-on event occurs.

Software reaches the register through a small CPU port with a select line, a write enable, write data and combinational read data. A written 0 clears the matching flag and a written 1 leaves it as it is. Software can therefore read the register early in boot and then clear any subset of the flags. A power-on event sets the power-on flag and clears the other flags in the same cycle. The power-on flag itself is cleared only by software.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst_n` is released and before any source fires, a selected read returns 0x00.
- R2: Flag positions in the read and write data: bit 0 is power-on, bit 1 is external pin, bit 2 is brown-out, bit 3 is watchdog and bit 4 is debug-port request. When the external, brown-out, watchdog or debug source fires, it sets only its own bit.
- R3: A power-on event sets bit 0 and clears bits 4..2. Bit 1 is don't-care after a power-on event and is not checked.
- R4: A selected write with a 0 in a flag bit position clears that flag. This holds for bits 4..1 and for the power-on flag at bit 0.
- R5: A selected write with a 1 in a flag bit position leaves that flag unchanged.
- R6: The power-on flag is not cleared by any source event. Software can clear it only by writing 0 to bit 0.
- R7: If a source event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: Bits 7..5 always read as 0, and writing to them has no effect.
- R9: While `cpu_sel` is low, writes are ignored and `cpu_rdata` reads 0x00.
- R10: A source input driven high before clock edge 1 shows in the read data after edge SYNC_STAGES+1 and not earlier. With the default SYNC_STAGES=2, that is three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low initialisation of the register and synchronisers |
| src_por | input | 1 | Power-on event, asynchronous |
| src_ext | input | 1 | External reset pin event, asynchronous |
| src_bod | input | 1 | Brown-out event, asynchronous |
| src_wdt | input | 1 | Watchdog event, asynchronous |
| src_dbg | input | 1 | Debug-port reset request, asynchronous |
| cpu_sel | input | 1 | Address match for this register |
| cpu_we | input | 1 | Write enable, used only while selected |
| cpu_wdata | input | DATA_W | Write data; a 0 in a flag position clears that flag |
| cpu_rdata | output | DATA_W | Read data; flags in bits 4..0, 0 when not selected |

## Verification
Any wrong flag state shows in the next selected read, because the read path is combinational from the flag register. A flag that is set or cleared wrongly is therefore visible one cycle after the faulty update. A fault in the synchroniser depth moves the moment a flag first appears, so the bench samples that moment to the exact edge. Faults in the update priority, such as a power-on that does not clear the other flags or a clear that beats a set, show up as a wrong bit pattern right after the contested cycle.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int RCR_NSRC  = 5;
    localparam int IDX_POR   = 0;
    localparam int IDX_EXT   = 1;
    localparam int IDX_BOD   = 2;
    localparam int IDX_WDT   = 3;
    localparam int IDX_DBG   = 4;

    typedef logic [RCR_NSRC-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
    } core_state_t;
endpackage

// File: rtl/rcr_sync.sv
module rcr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q << 1;
        chain_d[0] = async_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    // R10: the output follows the input delayed through the chain
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[0] |=> (chain_d[STAGES-1:0] != '0 || STAGES == 1 || chain_q[STAGES > 1 ? 1 : 0])); // R10
endmodule

// File: rtl/rcr_flag_core.sv
module rcr_flag_core
    import rcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  logic      wr_i,
    input  flag_vec_t wmask_i,
    output flag_vec_t flags_o
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)
            st_d.flags = st_q.flags & wmask_i;
        if (set_i[IDX_POR])
            st_d.flags = flag_vec_t'(1) << IDX_POR;
        st_d.flags = st_d.flags | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < RCR_NSRC; g++) begin : g_set_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> st_q.flags[g]); // R7
    end

    AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[IDX_POR] && set_i[IDX_DBG:IDX_BOD] == '0) |=> st_q.flags[IDX_DBG:IDX_BOD] == '0); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && set_i == '0) |=> $stable(st_q.flags)); // R9

    AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !set_i[IDX_POR]) |=>
            ((st_q.flags & $past(st_q.flags & wmask_i)) == $past(st_q.flags & wmask_i))); // R5

    AST_POR_ONLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags[IDX_POR] && !wr_i) |=> st_q.flags[IDX_POR]); // R6
endmodule

// File: rtl/rcr_bus_if.sv
module rcr_bus_if
    import rcr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  flag_vec_t         flags_i,
    output logic              wr_o,
    output flag_vec_t         wmask_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int RSVD_W = DATA_W - RCR_NSRC;

    always_comb begin
        wr_o    = sel_i & we_i;
        wmask_o = wdata_i[RCR_NSRC-1:0];
        rdata_o = '0;
        if (sel_i)
            rdata_o = {{RSVD_W{1'b0}}, flags_i};
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:RCR_NSRC] == '0); // R8

    AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> sel_i); // R9
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_por,
    input  logic              src_ext,
    input  logic              src_bod,
    input  logic              src_wdt,
    input  logic              src_dbg,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    flag_vec_t raw_src, sync_src, flags, wmask;
    logic      wr;

    always_comb begin
        raw_src          = '0;
        raw_src[IDX_POR] = src_por;
        raw_src[IDX_EXT] = src_ext;
        raw_src[IDX_BOD] = src_bod;
        raw_src[IDX_WDT] = src_wdt;
        raw_src[IDX_DBG] = src_dbg;
    end

    for (genvar g = 0; g < RCR_NSRC; g++) begin : g_sync
        rcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_src[g]),
            .sync_o  (sync_src[g])
        );
    end

    rcr_bus_if #(.DATA_W(DATA_W)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (cpu_sel),
        .we_i    (cpu_we),
        .wdata_i (cpu_wdata),
        .flags_i (flags),
        .wr_o    (wr),
        .wmask_o (wmask),
        .rdata_o (cpu_rdata)
    );

    rcr_flag_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (sync_src),
        .wr_i    (wr),
        .wmask_i (wmask),
        .flags_o (flags)
    );

    AST_DESEL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel |-> cpu_rdata == '0); // R9
endmodule

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_v = '0;
    logic       cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] exp_v = '0;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .src_por(src_v[0]), .src_ext(src_v[1]), .src_bod(src_v[2]),
        .src_wdt(src_v[3]), .src_dbg(src_v[4]),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SYNC + 2) @(negedge clk);
    endtask

    task automatic pulse_src(int idx);
        @(negedge clk) src_v[idx] = 1'b1;
        repeat (2) @(negedge clk);
        src_v[idx] = 1'b0;
        settle();
    endtask

    task automatic cpu_write(logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic t_reset();
        cpu_sel = 1'b1;
        check("R1 reset value", cpu_rdata, 8'h00);
    endtask

    task automatic t_latency();
        @(negedge clk) src_v[3] = 1'b1;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        check("R10 not yet visible", cpu_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check("R10 visible on edge SYNC+1", cpu_rdata, 8'h08);
        src_v[3] = 1'b0;
        exp_v = 8'h08;
        settle();
        check("R2 watchdog bit 3 sticky", cpu_rdata, exp_v);
    endtask

    task automatic t_sources();
        pulse_src(1); exp_v |= 8'h02;
        check("R2 external bit 1", cpu_rdata, exp_v);
        pulse_src(2); exp_v |= 8'h04;
        check("R2 brown-out bit 2", cpu_rdata, exp_v);
        pulse_src(4); exp_v |= 8'h10;
        check("R2 debug bit 4", cpu_rdata, exp_v);
    endtask

    task automatic t_write_ones();
        cpu_write(8'hFF);
        check("R5 write ones keeps flags", cpu_rdata, exp_v);
        check("R8 reserved bits zero", cpu_rdata & 8'hE0, 8'h00);
    endtask

    task automatic t_selective_clear();
        cpu_write(8'hF7); exp_v &= 8'hF7;
        check("R4 clear watchdog only", cpu_rdata, exp_v);
    endtask

    task automatic t_deselect();
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b1; cpu_wdata = 8'h00;
        @(negedge clk);
        check("R9 deselected read zero", cpu_rdata, 8'h00);
        cpu_we = 1'b0; cpu_sel = 1'b1;
        @(negedge clk);
        check("R9 deselected write ignored", cpu_rdata, exp_v);
    endtask

    task automatic t_por();
        pulse_src(0);
        check("R3 por sets bit0 clears 4..2", cpu_rdata & 8'hFD, 8'h01);
        pulse_src(3);
        check("R6 por flag survives watchdog", cpu_rdata & 8'hFD, 8'h09);
        cpu_write(8'hFE);
        check("R4 software clears por flag", cpu_rdata & 8'h01, 8'h00);
        cpu_write(8'h00);
        check("R4 clear all", cpu_rdata, 8'h00);
    endtask

    task automatic t_set_wins();
        @(negedge clk) src_v[2] = 1'b1;
        settle();
        cpu_write(8'h00);
        check("R7 set beats clear", cpu_rdata, 8'h04);
        src_v[2] = 1'b0;
        settle();
        cpu_write(8'hFB);
        check("R4 clear after release", cpu_rdata, 8'h00);
        cpu_write(8'hFF);
        check("R8 reserved still zero", cpu_rdata, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_sources();
        t_write_ones();
        t_selective_clear();
        t_deselect();
        t_por();
        t_set_wins();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule